// File: doc/BRIEF.md
# Software-Steerable Up Counter

This block is a free-running up counter placed in a user area of a larger chip. A management processor watches it, preloads it and can take over its clock and reset. Access runs through two paths: a 128-bit probe bus with per-bit output enables, and a Wishbone slave register. The count is returned on the low probe lines and also drives a group of general-purpose pads.

Each probe line has an active-low enable that says whether the management side drives it. By default the counter runs from the bus clock and bus reset. If software drives one dedicated probe line, that line becomes the counter clock. If it drives a second dedicated line, that line becomes the counter reset. A 32-bit group of probe lines can overwrite the count bit by bit for as long as those lines stay driven. A Wishbone write can also set the count, with byte granularity, and a Wishbone read returns the count.

Top module: `probe_counter_top`

## Requirements
- R1: When `probe_drv_n[64]` is 0, the counter and its bus port are clocked by `probe_in[64]` and edges of `bus_clk` have no effect. When `probe_drv_n[64]` is 1, `bus_clk` is the clock.
- R2: The synchronous reset is `bus_rst` when `probe_drv_n[65]` is 1, and `probe_in[65]` when it is 0. While reset is active, the count is 0 and `wb_ack` is 0.
- R3: With no load and no write, the count rises by one on each clock edge and wraps from 0xFFFFFFFF to 0.
- R4: `probe_out[31:0]` shows the current count. All other `probe_out` bits are 0.
- R5: `pad_out` equals count bits [7:0]. `pad_oe_n` is all ones while the block is in reset and all zeros otherwise.
- R6: Every bit i in [31:0] whose `probe_drv_n[32+i]` is 0 is loaded from `probe_in[32+i]` on each edge. The other bits keep their value, and the count does not increment while any such bit is driven. Counting resumes once every enable is back at 1.
- R7: A Wishbone write to word address `BASE_ADDR` replaces the count bytes whose `wb_sel` bit is set (sel bit k covers bits [8k+7:8k]). The other bytes hold, and the write takes priority over the increment.
- R8: A probe load takes priority over a Wishbone write in the same cycle. The write is still acknowledged but leaves the count unchanged.
- R9: An accepted access gets `wb_ack` high for exactly one cycle, on the edge after the request. A read returns the count as it stood at the accepting edge.
- R10: An access to any other word address gets no acknowledge and does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Default clock |
| bus_rst | input | 1 | Default synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write when 1, read when 0 |
| wb_adr | input | 32 | Byte address |
| wb_sel | input | 4 | Byte selects |
| wb_wdata | input | 32 | Write data |
| wb_ack | output | 1 | One-cycle acknowledge |
| wb_rdata | output | 32 | Read data |
| probe_in | input | 128 | Probe values driven by software |
| probe_drv_n | input | 128 | Per-bit probe drive enables, active low |
| probe_out | output | 128 | Probe values returned to software |
| pad_out | output | 8 | Pad data |
| pad_oe_n | output | 8 | Pad output enables, active low |

## Verification
The bench builds the block with its default parameters: a 128-bit probe bus, clock and reset on probe bits 64 and 65, preload on bits [63:32], 8 pads and the base address 0x30000000. These values put the 32-bit wrap, byte-select merges, partial per-bit preloads and collisions between a load and a write within reach of short directed sequences. A random phase mixes these with idle cycles. Because the clock and reset bits sit at fixed positions, the bench can toggle them by hand to run the counter while `bus_clk` keeps running.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned SEL_W = CNT_W / 8;

  typedef struct packed {
    logic             wr_en;
    logic [SEL_W-1:0] be;
    logic [CNT_W-1:0] wdata;
  } bus_wr_t;
endpackage

// File: rtl/pc_src_sel.sv
module pc_src_sel (
  input  logic bus_clk,
  input  logic bus_rst,
  input  logic sw_clk,
  input  logic sw_clk_drv_n,
  input  logic sw_rst,
  input  logic sw_rst_drv_n,
  output logic cnt_clk,
  output logic cnt_rst
);
  // software takes a source over only while it drives that probe line
  assign cnt_clk = sw_clk_drv_n ? bus_clk : sw_clk;
  assign cnt_rst = sw_rst_drv_n ? bus_rst : sw_rst;
endmodule

// File: rtl/pc_wb_port.sv
module pc_wb_port
  import pc_pkg::*;
#(
  parameter int unsigned       ADR_W     = 32,
  parameter logic [ADR_W-1:0]  BASE_ADDR = 32'h3000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [ADR_W-1:0] adr,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cur,
  output bus_wr_t          wr,
  output logic             ack,
  output logic [CNT_W-1:0] rdata
);
  localparam int unsigned OFS_W = $clog2(SEL_W);

  logic hit, accept;
  logic unused_adr_low;

  assign unused_adr_low = ^adr[OFS_W-1:0];
  assign hit    = (adr[ADR_W-1:OFS_W] == BASE_ADDR[ADR_W-1:OFS_W]);
  assign accept = cyc & stb & hit & ~ack;

  always_comb begin
    wr.wr_en = accept & we;
    wr.be    = sel;
    wr.wdata = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= accept;
      if (accept && !we) rdata <= cur;
    end
  end
endmodule

// File: rtl/pc_count_core.sv
module pc_count_core
  import pc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ld_mask,
  input  logic [CNT_W-1:0] ld_val,
  input  bus_wr_t          wr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] merged, nxt;

  for (genvar b = 0; b < SEL_W; b++) begin : g_byte
    assign merged[b*8 +: 8] = wr.be[b] ? wr.wdata[b*8 +: 8] : count[b*8 +: 8];
  end

  // probe load, then bus write, then increment
  always_comb begin
    if (|ld_mask)      nxt = (count & ~ld_mask) | (ld_val & ld_mask);
    else if (wr.wr_en) nxt = merged;
    else               nxt = count + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= nxt;
  end
endmodule

// File: rtl/probe_counter_top.sv
module probe_counter_top
  import pc_pkg::*;
#(
  parameter int unsigned      PROBE_W   = 128,
  parameter int unsigned      PAD_N     = 8,
  parameter int unsigned      CLK_BIT   = 64,
  parameter int unsigned      RST_BIT   = 65,
  parameter int unsigned      LOAD_LSB  = 32,
  parameter int unsigned      ADR_W     = 32,
  parameter logic [ADR_W-1:0] BASE_ADDR = 32'h3000_0000
) (
  input  logic               bus_clk,
  input  logic               bus_rst,
  input  logic               wb_cyc,
  input  logic               wb_stb,
  input  logic               wb_we,
  input  logic [ADR_W-1:0]   wb_adr,
  input  logic [SEL_W-1:0]   wb_sel,
  input  logic [CNT_W-1:0]   wb_wdata,
  output logic               wb_ack,
  output logic [CNT_W-1:0]   wb_rdata,
  input  logic [PROBE_W-1:0] probe_in,
  input  logic [PROBE_W-1:0] probe_drv_n,
  output logic [PROBE_W-1:0] probe_out,
  output logic [PAD_N-1:0]   pad_out,
  output logic [PAD_N-1:0]   pad_oe_n
);
  logic             cnt_clk, cnt_rst;
  logic [CNT_W-1:0] count;
  bus_wr_t          wr;
  logic             unused_probe;

  assign unused_probe = ^{probe_in, probe_drv_n};

  pc_src_sel u_src (
    .bus_clk      (bus_clk),
    .bus_rst      (bus_rst),
    .sw_clk       (probe_in[CLK_BIT]),
    .sw_clk_drv_n (probe_drv_n[CLK_BIT]),
    .sw_rst       (probe_in[RST_BIT]),
    .sw_rst_drv_n (probe_drv_n[RST_BIT]),
    .cnt_clk      (cnt_clk),
    .cnt_rst      (cnt_rst)
  );

  pc_wb_port #(.ADR_W(ADR_W), .BASE_ADDR(BASE_ADDR)) u_wb (
    .clk   (cnt_clk),
    .rst   (cnt_rst),
    .cyc   (wb_cyc),
    .stb   (wb_stb),
    .we    (wb_we),
    .adr   (wb_adr),
    .sel   (wb_sel),
    .wdata (wb_wdata),
    .cur   (count),
    .wr    (wr),
    .ack   (wb_ack),
    .rdata (wb_rdata)
  );

  pc_count_core u_core (
    .clk     (cnt_clk),
    .rst     (cnt_rst),
    .ld_mask (~probe_drv_n[LOAD_LSB +: CNT_W]),
    .ld_val  (probe_in[LOAD_LSB +: CNT_W]),
    .wr      (wr),
    .count   (count)
  );

  always_ff @(posedge cnt_clk) begin
    if (cnt_rst) pad_oe_n <= '1;
    else         pad_oe_n <= '0;
  end

  always_comb begin
    probe_out            = '0;
    probe_out[CNT_W-1:0] = count;
  end

  assign pad_out = count[PAD_N-1:0];
endmodule

// File: rtl/probe_counter_chk.sv
module probe_counter_chk
  import pc_pkg::*;
#(
  parameter int unsigned      PROBE_W   = 128,
  parameter int unsigned      PAD_N     = 8,
  parameter int unsigned      CLK_BIT   = 64,
  parameter int unsigned      RST_BIT   = 65,
  parameter int unsigned      LOAD_LSB  = 32,
  parameter int unsigned      ADR_W     = 32,
  parameter logic [ADR_W-1:0] BASE_ADDR = 32'h3000_0000
) (
  input logic               bus_clk,
  input logic               bus_rst,
  input logic               wb_cyc,
  input logic               wb_stb,
  input logic               wb_we,
  input logic [ADR_W-1:0]   wb_adr,
  input logic               wb_ack,
  input logic [PROBE_W-1:0] probe_in,
  input logic [PROBE_W-1:0] probe_drv_n,
  input logic [PROBE_W-1:0] probe_out,
  input logic [PAD_N-1:0]   pad_out,
  input logic [PAD_N-1:0]   pad_oe_n
);
  localparam int unsigned OFS_W = $clog2(SEL_W);

  logic bus_mode, wr_hit, no_load;
  assign bus_mode = probe_drv_n[CLK_BIT] && probe_drv_n[RST_BIT];
  assign wr_hit   = wb_cyc && wb_stb && wb_we && !wb_ack &&
                    (wb_adr[ADR_W-1:OFS_W] == BASE_ADDR[ADR_W-1:OFS_W]);
  assign no_load  = &probe_drv_n[LOAD_LSB +: CNT_W];

  a_r2_reset_clears: assert property (@(posedge bus_clk)
    (bus_rst && bus_mode) |=> (!bus_mode || probe_out[CNT_W-1:0] == '0));

  a_r3_step_one: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_mode && no_load && !wr_hit) |=>
      (!bus_mode || probe_out[CNT_W-1:0] == $past(probe_out[CNT_W-1:0]) + 1'b1));

  a_r5_pads_follow: assert property (@(posedge bus_clk) disable iff (bus_rst)
    pad_out == probe_out[PAD_N-1:0]);

  a_r5_oe_active: assert property (@(posedge bus_clk) disable iff (bus_rst)
    bus_mode |=> (!bus_mode || pad_oe_n == '0));

  a_r6_full_load: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_mode && probe_drv_n[LOAD_LSB +: CNT_W] == '0) |=>
      (!bus_mode || probe_out[CNT_W-1:0] == $past(probe_in[LOAD_LSB +: CNT_W])));

  a_r9_ack_single: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_mode && wb_ack) |=> (!bus_mode || !wb_ack));

  a_r4_upper_zero: assert property (@(posedge bus_clk)
    probe_out[PROBE_W-1:CNT_W] == '0);
endmodule

bind probe_counter_top probe_counter_chk #(
  .PROBE_W(PROBE_W), .PAD_N(PAD_N), .CLK_BIT(CLK_BIT), .RST_BIT(RST_BIT),
  .LOAD_LSB(LOAD_LSB), .ADR_W(ADR_W), .BASE_ADDR(BASE_ADDR)
) chk_i (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
  .wb_we(wb_we), .wb_adr(wb_adr), .wb_ack(wb_ack), .probe_in(probe_in),
  .probe_drv_n(probe_drv_n), .probe_out(probe_out), .pad_out(pad_out),
  .pad_oe_n(pad_oe_n)
);

// File: tb/probe_counter_top_tb_top.sv
module probe_counter_top_tb_top;
  localparam logic [31:0] BASE = 32'h3000_0000;

  logic         bus_clk = 1'b0;
  logic         bus_rst = 1'b1;
  logic         wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [31:0]  wb_adr = BASE;
  logic [3:0]   wb_sel = 4'hF;
  logic [31:0]  wb_wdata = '0;
  logic         wb_ack;
  logic [31:0]  wb_rdata;
  logic [127:0] probe_in = '0;
  logic [127:0] probe_drv_n = '1;
  logic [127:0] probe_out;
  logic [7:0]   pad_out, pad_oe_n;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_cnt = '0;
  logic [31:0] prev_cnt;

  always #4 bus_clk = ~bus_clk;

  probe_counter_top dut_i (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_we(wb_we), .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_wdata(wb_wdata),
    .wb_ack(wb_ack), .wb_rdata(wb_rdata), .probe_in(probe_in),
    .probe_drv_n(probe_drv_n), .probe_out(probe_out), .pad_out(pad_out),
    .pad_oe_n(pad_oe_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // next count from the requirement priorities: load, write, increment
  function automatic logic [31:0] next_count(input logic [31:0] cur);
    logic [31:0] m, r;
    logic wr;
    m  = ~probe_drv_n[63:32];
    wr = wb_cyc && wb_stb && wb_we && (wb_adr[31:2] == BASE[31:2]);
    if (m != 0) r = (cur & ~m) | (probe_in[63:32] & m);
    else if (wr) begin
      r = cur;
      for (int k = 0; k < 4; k++) if (wb_sel[k]) r[k*8 +: 8] = wb_wdata[k*8 +: 8];
    end else r = cur + 32'd1;
    return r;
  endfunction

  // one bus_clk edge in bus-clock mode
  task automatic step();
    logic rst_eff;
    @(posedge bus_clk);
    rst_eff  = probe_drv_n[65] ? bus_rst : probe_in[65];
    prev_cnt = exp_cnt;
    exp_cnt  = rst_eff ? 32'd0 : next_count(exp_cnt);
    @(negedge bus_clk);
  endtask

  task automatic chk_count(input string req);
    chk(req, probe_out[31:0], exp_cnt);
    chk(req, {24'd0, pad_out}, {24'd0, exp_cnt[7:0]});
  endtask

  task automatic bus_idle();
    wb_cyc = 0; wb_stb = 0; wb_we = 0; wb_adr = BASE;
  endtask

  task automatic bus_write(input logic [31:0] adr, input logic [3:0] sel, input logic [31:0] d,
                           input logic exp_ack, input string req);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = adr; wb_sel = sel; wb_wdata = d;
    step();
    chk(req, {31'd0, wb_ack}, {31'd0, exp_ack});
    chk_count(req);
    bus_idle();
    step();
    chk("R9 ack one cycle", {31'd0, wb_ack}, 32'd0);
  endtask

  task automatic bus_read(input string req);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = BASE;
    step();
    chk(req, {31'd0, wb_ack}, 32'd1);
    chk(req, wb_rdata, prev_cnt);
    bus_idle();
    step();
    chk("R9 ack drops", {31'd0, wb_ack}, 32'd0);
  endtask

  task automatic sw_pulse();
    #1 probe_in[64] = 1'b1;
    #1 probe_in[64] = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge bus_clk);
    repeat (3) step();
    // R2 / R5 reset state
    chk("R2 reset count", probe_out[31:0], 32'd0);
    chk("R2 reset ack", {31'd0, wb_ack}, 32'd0);
    chk("R5 oe in reset", {24'd0, pad_oe_n}, 32'hFF);
    chk("R4 upper probes zero", probe_out[127:96] | probe_out[95:64] | probe_out[63:32], 32'd0);

    bus_rst = 0;
    step();
    chk_count("R3 first count");
    step();
    chk("R5 oe active", {24'd0, pad_oe_n}, 32'd0);
    for (int i = 0; i < 5; i++) begin step(); chk_count("R3 increment"); end

    // R7 writes
    bus_write(BASE, 4'hF, 32'h1234_5678, 1'b1, "R7 full write");
    bus_write(BASE + 32'd2, 4'b0101, 32'hAABB_CCDD, 1'b1, "R7 byte select");
    // R3 wrap
    bus_write(BASE, 4'hF, 32'hFFFF_FFFF, 1'b1, "R3 load all ones");
    chk("R3 wrap", probe_out[31:0], 32'd0);
    bus_read("R9 read value");
    // R10 unmapped
    bus_write(BASE + 32'h100, 4'hF, 32'h5555_0000, 1'b0, "R10 unmapped ignored");

    // R6 full and partial preload
    probe_in[63:32] = 32'hCAFE_0000;
    probe_drv_n[63:32] = '0;
    repeat (3) begin step(); chk_count("R6 load holds"); end
    bus_write(BASE, 4'hF, 32'h0101_0101, 1'b1, "R8 load beats write");
    probe_drv_n[47:32] = '1;
    probe_in[63:32] = 32'h1234_0000;
    step(); chk_count("R6 partial load");
    probe_drv_n[63:32] = '1;
    step(); step(); chk_count("R6 counting resumes");

    // R2 reset taken from probe bit 65 under bus clock
    probe_drv_n[65] = 0; probe_in[65] = 1;
    step(); chk_count("R2 probe reset");
    probe_in[65] = 0; bus_rst = 1;
    step(); step(); chk_count("R2 bus reset ignored");
    bus_rst = 0; probe_drv_n[65] = 1;
    step(); chk_count("R2 back to bus reset");

    // R1 probe clock
    probe_in[64] = 0; probe_drv_n[64] = 0;
    @(negedge bus_clk); @(negedge bus_clk);
    chk("R1 bus edges ignored", probe_out[31:0], exp_cnt);
    for (int i = 0; i < 5; i++) begin sw_pulse(); exp_cnt = exp_cnt + 32'd1; end
    chk("R1 probe clock counts", probe_out[31:0], exp_cnt);
    probe_drv_n[65] = 0; probe_in[65] = 1;
    sw_pulse(); exp_cnt = '0;
    chk("R2 probe reset on probe clock", probe_out[31:0], 32'd0);
    chk("R5 oe under probe reset", {24'd0, pad_oe_n}, 32'hFF);
    probe_in[65] = 0;
    sw_pulse(); exp_cnt = 32'd1;
    chk("R1 count after probe reset", probe_out[31:0], 32'd1);
    @(negedge bus_clk);
    probe_drv_n[65] = 1; probe_drv_n[64] = 1;
    step(); chk_count("R1 bus clock restored");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 5;
      probe_in[63:32] = $urandom;
      probe_in[127:66] = {$urandom, $urandom};
      if (op == 3) begin
        probe_drv_n[63:32] = $urandom | $urandom;
        step(); chk_count("R6 random load");
        probe_drv_n[63:32] = '1;
      end else if (op == 1) begin
        bus_write(BASE, 4'($urandom), $urandom, 1'b1, "R7 random write");
      end else if (op == 2) begin
        bus_read("R9 random read");
      end else if (op == 4) begin
        probe_drv_n[63:32] = ~(32'd1 << ($urandom % 32));
        bus_write(BASE, 4'hF, $urandom, 1'b1, "R8 random collision");
        probe_drv_n[63:32] = '1;
      end else begin
        step(); chk_count("R3 random idle");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule